// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

This block walks every erase block of a NAND device once and builds a one-bit-per-block table of factory bad marks. For each block it asks a separate page-read engine for the byte at the first spare-area column. It asks first for page 0 and, when that byte is clean, for page 1. A block counts as good only if every byte it checked reads all-ones. The block never touches the flash pins itself. It sends a block, page and column over a valid/ready request channel and takes one byte back over a valid/ready response channel.

Software or a neighbouring controller pulses `start`. It watches `busy`, or waits for the single-cycle `done`, and then reads the table one entry at a time through a combinational host port. A saturating count of bad blocks is available at all times. A new scan wipes the previous table and count. The table lives in flip-flops sized by `NUM_BLOCKS`, 2048 by default.

Back-pressure rules: the scanner holds a request on `req_valid` with its fields unchanged until `req_ready` is sampled high. Only one request is ever outstanding. After a request is accepted the scanner raises `rsp_ready` and keeps it high until `rsp_valid` arrives. `rsp_ready` is never high while `req_valid` is high.

Top module: `bad_block_scanner`

## Requirements
- R1: After reset `busy`, `done`, `req_valid`, `rsp_ready` are 0, `bad_count` is 0 and every table entry reads 0 (0 = good, 1 = bad).
- R2: A `start` sampled while idle raises `busy` on the next cycle, and the first request carries block 0, page 0 and column `SPARE_COL` (2048 by default).
- R3: Blocks are requested in ascending order from 0, one block at a time, and the scan ends after block `NUM_BLOCKS-1`.
- R4: Page 1 of a block is requested only when the page-0 byte of that block read 8'hFF. Otherwise the scanner moves straight to the next block.
- R5: A table entry becomes 1 exactly when any byte checked for that block differs from 8'hFF.
- R6: `bad_count` equals the number of bad blocks found in the current scan and saturates at 2^`CNT_W`-1.
- R7: `done` is high for exactly one cycle, the cycle after the last response is accepted, and `busy` is already 0 in that cycle.
- R8: `start` while `busy` is high is ignored: the request sequence and the results continue unchanged.
- R9: A accepted `start` clears the whole table and `bad_count` to 0 on the same edge on which `busy` rises.
- R10: `host_bad` shows the current entry for `host_idx` combinationally, also during a scan. An entry written by a response reads its new value from the cycle after that response handshake.
- R11: A request stays on `req_valid` with stable block, page and column until accepted. `rsp_ready` is never high together with `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at scan completion |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read engine accepts the request |
| req_block | output | BLK_W (11) | Block address of the request |
| req_page | output | PG_W (6) | Page within the block (0 or 1) |
| req_col | output | COL_W (12) | Column address, always the first spare byte |
| rsp_valid | input | 1 | Returned byte valid |
| rsp_ready | output | 1 | Scanner waits for the returned byte |
| rsp_data | input | DATA_W (8) | Returned byte |
| host_idx | input | BLK_W (11) | Block index for a table read |
| host_bad | output | 1 | Table entry at host_idx, 1 = bad |
| bad_count | output | CNT_W (12) | Saturating number of bad blocks |

## Verification
Two functions can fall in the same cycle: a host read of a table entry, and the write of that same entry by a bad response. The bench aims the host index at the block whose bad byte is being handed over, in the cycle of the handshake. It expects the old value (good) before the edge and the bad mark one cycle later. A second collision is a `start` pulse landing in the middle of a scan. The bench judges it through the request-sequence model, which would flag any return to block 0, and through the final table and count.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_REQ  = 2'd1,
    SCAN_WAIT = 2'd2
  } scan_state_e;
endpackage

// File: rtl/bbs_sequencer.sv
module bbs_sequencer
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS = 2048,
  parameter int BLK_W      = 11,
  parameter int PG_W       = 6,
  parameter int COL_W      = 12,
  parameter int DATA_W     = 8,
  parameter int SPARE_COL  = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BLK_W-1:0]  req_block,
  output logic [PG_W-1:0]   req_page,
  output logic [COL_W-1:0]  req_col,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              scan_clear,
  output logic              mark_bad
);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [COL_W-1:0] COL_VAL  = COL_W'(SPARE_COL);

  scan_state_e      state_q;
  logic [BLK_W-1:0] blk_q;
  logic             second_q;
  logic             done_q;
  logic             rsp_take;
  logic             byte_bad;
  logic             block_end;

  assign rsp_take   = (state_q == SCAN_WAIT) && rsp_valid;
  assign byte_bad   = (rsp_data != {DATA_W{1'b1}});
  assign mark_bad   = rsp_take && byte_bad;
  assign block_end  = rsp_take && (byte_bad || second_q);
  assign scan_clear = (state_q == SCAN_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SCAN_IDLE;
      blk_q    <= '0;
      second_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SCAN_IDLE: begin
          if (start) begin
            state_q  <= SCAN_REQ;
            blk_q    <= '0;
            second_q <= 1'b0;
          end
        end
        SCAN_REQ: begin
          if (req_ready) state_q <= SCAN_WAIT;
        end
        SCAN_WAIT: begin
          if (block_end) begin
            second_q <= 1'b0;
            if (blk_q == LAST_BLK) begin
              state_q <= SCAN_IDLE;
              done_q  <= 1'b1;
            end else begin
              blk_q   <= blk_q + 1'b1;
              state_q <= SCAN_REQ;
            end
          end else if (rsp_take) begin
            second_q <= 1'b1;
            state_q  <= SCAN_REQ;
          end
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != SCAN_IDLE);
  assign done      = done_q;
  assign req_valid = (state_q == SCAN_REQ);
  assign rsp_ready = (state_q == SCAN_WAIT);
  assign req_block = blk_q;
  assign req_page  = {{(PG_W-1){1'b0}}, second_q};
  assign req_col   = COL_VAL;
endmodule

// File: rtl/bbs_table.sv
module bbs_table #(
  parameter int NUM_BLOCKS = 2048,
  parameter int BLK_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_idx,
  input  logic [BLK_W-1:0] rd_idx,
  output logic             rd_bad
);
  logic [NUM_BLOCKS-1:0] bad_q;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  bad_q[g] <= 1'b0;
      else if (clear)                              bad_q[g] <= 1'b0;
      else if (wr_en && (wr_idx == BLK_W'(g)))     bad_q[g] <= 1'b1;
    end
  end

  always_comb begin
    rd_bad = 1'b0;
    if (int'(rd_idx) < NUM_BLOCKS) rd_bad = bad_q[rd_idx];
  end
endmodule

// File: rtl/bbs_counter.sv
module bbs_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clear)                    cnt_q <= '0;
    else if (inc && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/bad_block_scanner.sv
module bad_block_scanner #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int COL_W           = 12,
  parameter int SPARE_COL       = 2048,
  parameter int DATA_W          = 8,
  parameter int CNT_W           = 12
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  output logic                                   busy,
  output logic                                   done,
  output logic                                   req_valid,
  input  logic                                   req_ready,
  output logic [$clog2(NUM_BLOCKS)-1:0]          req_block,
  output logic [$clog2(PAGES_PER_BLOCK)-1:0]     req_page,
  output logic [COL_W-1:0]                       req_col,
  input  logic                                   rsp_valid,
  output logic                                   rsp_ready,
  input  logic [DATA_W-1:0]                      rsp_data,
  input  logic [$clog2(NUM_BLOCKS)-1:0]          host_idx,
  output logic                                   host_bad,
  output logic [CNT_W-1:0]                       bad_count
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK);

  logic scan_clear;
  logic mark_bad;

  bbs_sequencer #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .PG_W(PG_W),
    .COL_W(COL_W), .DATA_W(DATA_W), .SPARE_COL(SPARE_COL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_block(req_block),
    .req_page(req_page), .req_col(req_col), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .scan_clear(scan_clear), .mark_bad(mark_bad)
  );

  bbs_table #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_table (
    .clk(clk), .rst_n(rst_n), .clear(scan_clear), .wr_en(mark_bad),
    .wr_idx(req_block), .rd_idx(host_idx), .rd_bad(host_bad)
  );

  bbs_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clear(scan_clear), .inc(mark_bad),
    .count(bad_count)
  );
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
  parameter int BLK_W = 11,
  parameter int PG_W  = 6,
  parameter int COL_W = 12,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             req_valid,
  input logic             req_ready,
  input logic [BLK_W-1:0] req_block,
  input logic [PG_W-1:0]  req_page,
  input logic [COL_W-1:0] req_col,
  input logic             rsp_ready,
  input logic [CNT_W-1:0] bad_count
);
  // R11: a stalled request keeps its fields
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_block) &&
                                   $stable(req_page) && $stable(req_col)));

  // R11: never awaiting a byte while a request is offered
  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R7: done is a single pulse and busy is already low
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: a scan opens on block 0, page 0
  assert_first_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (req_valid && req_block == '0 && req_page == '0));

  // R4: only pages 0 and 1 are ever requested
  assert_page_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_page <= PG_W'(1)));

  // R6: count never falls during a scan
  assert_count_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (bad_count >= $past(bad_count)));
endmodule

bind bad_block_scanner bbs_checker #(
  .BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .req_valid(req_valid), .req_ready(req_ready), .req_block(req_block),
  .req_page(req_page), .req_col(req_col), .rsp_ready(rsp_ready),
  .bad_count(bad_count)
);

// File: tb/bad_block_scanner_bench.sv
module bad_block_scanner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 32;
  localparam int BW   = 5;
  localparam int PW   = 6;
  localparam int CW   = 12;
  localparam int CNTW = 4;
  localparam int SAT  = 15;
  localparam int SPARE = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, req_valid, rsp_ready, host_bad;
  logic req_ready = 1'b0;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic [BW-1:0] req_block;
  logic [PW-1:0] req_page;
  logic [CW-1:0] req_col;
  logic [BW-1:0] host_idx = '0;
  logic [CNTW-1:0] bad_count;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mark0 [NB];
  logic [7:0] mark1 [NB];
  int exp_blk, exp_pg;
  bit scanning = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bad_block_scanner #(.NUM_BLOCKS(NB), .CNT_W(CNTW)) u_bad_block_scanner (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_block(req_block),
    .req_page(req_page), .req_col(req_col), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .host_idx(host_idx),
    .host_bad(host_bad), .bad_count(bad_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit blk_is_bad(input int b);
    return (mark0[b] != 8'hFF) || (mark1[b] != 8'hFF);
  endfunction

  function automatic int exp_count();
    int c = 0;
    for (int b = 0; b < NB; b++) if (blk_is_bad(b)) c++;
    return (c > SAT) ? SAT : c;
  endfunction

  // Read engine model with random back-pressure and latency
  initial begin
    bit pending = 0;
    int dly = 0;
    int cb = 0;
    int cp = 0;
    bit chk_pend = 0;
    forever begin
      @(negedge clk);
      if (chk_pend) begin
        check(host_bad == 1'b1, "R10 entry set after handshake", host_bad, 1);
        chk_pend = 0;
      end
      if (pending && dly == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = (cp == 0) ? mark0[cb] : mark1[cb];
      end else begin
        rsp_valid = 1'b0;
        if (pending) dly--;
      end
      req_ready = !pending && ($urandom_range(0, 3) != 0);
      #1;
      if (req_valid && req_ready) begin
        check(int'(req_block) == exp_blk && int'(req_page) == exp_pg,
              "R3/R4 request order", int'(req_block) * 100 + int'(req_page),
              exp_blk * 100 + exp_pg);
        check(int'(req_col) == SPARE, "R2 spare column", int'(req_col), SPARE);
        cb = int'(req_block);
        cp = int'(req_page);
        pending = 1;
        dly = $urandom_range(0, 3);
      end else if (rsp_valid && rsp_ready) begin
        pending = 0;
        if (rsp_data != 8'hFF || cp == 1) begin
          exp_blk++;
          exp_pg = 0;
        end else begin
          exp_pg = 1;
        end
        if (rsp_data != 8'hFF && scanning) begin
          host_idx = BW'(cb);
          #1;
          check(host_bad == 1'b0, "R10 old value in write cycle", host_bad, 0);
          chk_pend = 1;
        end
      end
    end
  end

  task automatic run_scan();
    exp_blk = 0;
    exp_pg  = 0;
    @(negedge clk);
    start = 1'b1;
    scanning = 1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(bad_count == '0, "R9 count cleared at start", int'(bad_count), 0);
    repeat ($urandom_range(5, 40)) @(negedge clk);
    if (busy) begin
      start = 1'b1;            // R8: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R7 busy low with done", busy, 0);
    check(exp_blk == NB, "R3 all blocks visited", exp_blk, NB);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    scanning = 0;
    for (int b = 0; b < NB; b++) begin
      host_idx = BW'(b);
      #1;
      check(host_bad == blk_is_bad(b), "R5 table entry", host_bad, int'(blk_is_bad(b)));
    end
    check(int'(bad_count) == exp_count(), "R6 bad count", int'(bad_count), exp_count());
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin mark0[b] = 8'hFF; mark1[b] = 8'hFF; end
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
    check(req_valid == 0 && rsp_ready == 0, "R1 reset handshakes", {req_valid, rsp_ready}, 0);
    check(bad_count == '0, "R1 reset count", int'(bad_count), 0);
    rst_n = 1'b1;
    for (int b = 0; b < NB; b++) begin
      host_idx = BW'(b);
      #1;
      check(host_bad == 1'b0, "R1 table all good", host_bad, 0);
    end

    // all good
    run_scan();

    // directed corners plus random marks
    for (int b = 0; b < NB; b++) begin
      int k = $urandom_range(0, 3);
      mark0[b] = (k == 0) ? 8'($urandom_range(0, 254)) : 8'hFF;
      mark1[b] = (k == 1) ? 8'($urandom_range(0, 254)) : 8'hFF;
    end
    mark0[0] = 8'h00; mark1[0] = 8'hFF;
    mark0[NB-1] = 8'hFF; mark1[NB-1] = 8'hFE;
    mark0[1] = 8'h7F; mark1[1] = 8'hFF;
    mark0[2] = 8'hFF; mark1[2] = 8'hFF;
    run_scan();

    // heavy damage, count saturates (R6)
    for (int b = 0; b < NB; b++) begin
      mark0[b] = (b % 4 != 3) ? 8'($urandom_range(0, 254)) : 8'hFF;
      mark1[b] = 8'hFF;
    end
    run_scan();

    // clean device after a dirty scan: stale entries must vanish (R9)
    for (int b = 0; b < NB; b++) begin mark0[b] = 8'hFF; mark1[b] = 8'hFF; end
    run_scan();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule